// File: doc/BRIEF.md
# Supply Power Supervisor

This block decides whether the system supplies are switched on and when the master reset is released. It sits in the always-powered domain and is clocked whenever a battery is fitted. The supplies come on for three reasons. The first is connecting the battery, which is the release of the block's own power-on reset. The second is the power key being held low. The third is a charger becoming present. The key and charger inputs are synchronised and debounced before they act.

While the supplies are on, the microcontroller must keep sending a keep-alive pulse. Only a rising edge of that line counts. If no edge arrives within the timeout, the supplies are cut. No input turns the supplies off directly; the keep-alive simply stops arriving. After a cut the block waits through a lockout window. During that window it ignores every wake-up source. After the window it returns to the off state, where a wake-up source that is still present starts the supplies again.

Two comparator flags give the battery level: one above the reset level and one above the higher release level. The master reset is held while the supplies are off. It is also held while the battery is below the reset level. With a charger present, the reset is released only once the battery passes the higher release level.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rst_n` is low, `supply_en` is 0 and `mrst_n` is 0. On the first clock edge after `rst_n` rises (battery attached), `supply_en` goes to 1.
- R2: With the supplies off, driving `key_n` to 0 for at least `DEB_CYCLES` clocks turns `supply_en` on, exactly `DEB_CYCLES`+3 edges after the change. A low pulse shorter than `DEB_CYCLES` clocks has no effect.
- R3: With the supplies off, driving `chg_det` to 1 turns `supply_en` on, exactly `DEB_CYCLES`+3 edges after the change.
- R4: Each rising edge on `keepalive` restarts the timeout. With edges spaced at most `KA_TIMEOUT`-1 clocks apart, the supplies stay on. With a spacing of `KA_TIMEOUT` or more, they are cut.
- R5: With no keep-alive edge, `supply_en` falls exactly `KA_TIMEOUT` clocks after it rose.
- R6: `keepalive` held high counts as one edge only. The supplies are cut `KA_TIMEOUT`+3 clocks after the line was driven high.
- R7: After a cut, `supply_en` stays 0 for `LOCKOUT_CYCLES`+1 edges, even while a wake-up source is present. It comes back on the next edge only if a wake-up source is still present.
- R8: No input turns the supplies off while the keep-alive is fed. Holding `key_n` low while the supplies are on leaves `supply_en` at 1.
- R9: `mrst_n` is 0 while the supplies are off. When no charger is present, `mrst_n` goes to 1 once `bat_above_reset` is 1. When a charger is present, it goes to 1 only once `bat_above_release` is 1.
- R10: Once released, `mrst_n` returns to 0 only when `bat_above_reset` goes to 0. This holds even with a charger present and `bat_above_release` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset of the always-on domain; its release means a battery was attached |
| key_n | input | 1 | Power key, low when pressed (pulled up when idle) |
| chg_det | input | 1 | Charger present flag, high when a charger is detected |
| keepalive | input | 1 | Keep-alive line from the microcontroller; rising edges refresh the timeout |
| bat_above_reset | input | 1 | Comparator flag: battery above the reset level |
| bat_above_release | input | 1 | Comparator flag: battery above the higher release level |
| supply_en | output | 1 | Enables the system supplies |
| mrst_n | output | 1 | Active-low master reset for the system |

## Verification
The properties assume that the comparator flags and the keep-alive line are slow, level-like signals. They are taken to come from a single clock domain or to be stable for at least two clocks, so that the two-stage synchronisers see each change. The timeout is assumed to be at least three clocks and the debounce at least two. The stimulus holds each keep-alive pulse high for two clocks and changes the battery flags only between settled checks. It sweeps the keep-alive spacing and the key glitch width across their acceptance boundaries, with the expected on or off state computed from the parameters.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    typedef enum logic [1:0] {
        PS_ATTACH = 2'd0,
        PS_ON     = 2'd1,
        PS_LOCK   = 2'd2,
        PS_OFF    = 2'd3
    } pwr_state_e;

    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/pwr_deb.sv
module pwr_deb #(
    parameter int   HOLD = 4,
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    import pwr_sup_pkg::*;

    localparam int CW = cnt_width(HOLD);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d      = deb_q;
        deb_d.sync = {deb_q.sync[0], raw};
        if (deb_q.sync[1] == deb_q.stable) begin
            deb_d.cnt = '0;
        end else if (deb_q.cnt == CW'(HOLD - 1)) begin
            deb_d.stable = deb_q.sync[1];
            deb_d.cnt    = '0;
        end else begin
            deb_d.cnt = deb_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deb_q.sync   <= {2{IDLE}};
            deb_q.stable <= IDLE;
            deb_q.cnt    <= '0;
        end else begin
            deb_q <= deb_d;
        end
    end

    assign level = deb_q.stable;

    // A change of the filtered level needs the synchronised input settled at it
    assert_deb_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_q.stable != $past(deb_q.stable)) |->
            ($past(deb_q.sync[1], 1) == deb_q.stable && $past(deb_q.sync[1], 2) == deb_q.stable));

endmodule

// File: rtl/pwr_ka.sv
module pwr_ka #(
    parameter int TIMEOUT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ka_raw,
    input  logic run,
    output logic expire
);
    import pwr_sup_pkg::*;

    localparam int CW = cnt_width(TIMEOUT);

    typedef struct packed {
        logic [1:0]    sync;
        logic          prev;
        logic [CW-1:0] cnt;
    } ka_t;

    ka_t  ka_d, ka_q;
    logic rise;

    assign rise = ka_q.sync[1] & ~ka_q.prev;

    always_comb begin
        ka_d      = ka_q;
        ka_d.sync = {ka_q.sync[0], ka_raw};
        ka_d.prev = ka_q.sync[1];
        if (!run || rise) begin
            ka_d.cnt = '0;
        end else if (ka_q.cnt != CW'(TIMEOUT - 1)) begin
            ka_d.cnt = ka_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ka_q <= '0;
        end else begin
            ka_q <= ka_d;
        end
    end

    assign expire = run && (ka_q.cnt == CW'(TIMEOUT - 1));

    // An edge one cycle ago must have restarted the window (TIMEOUT >= 3)
    assert_ka_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !$past(rise));

endmodule

// File: rtl/pwr_rgate.sv
module pwr_rgate (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_on,
    input  logic chg_on,
    input  logic lo_raw,
    input  logic hi_raw,
    output logic mrst_n
);
    typedef struct packed {
        logic [1:0] lo_s;
        logic [1:0] hi_s;
        logic       hold;
    } rg_t;

    rg_t rg_d, rg_q;

    always_comb begin
        rg_d      = rg_q;
        rg_d.lo_s = {rg_q.lo_s[0], lo_raw};
        rg_d.hi_s = {rg_q.hi_s[0], hi_raw};
        if (!supply_on) begin
            rg_d.hold = 1'b1;
        end else if (rg_q.hold) begin
            if (chg_on ? rg_q.hi_s[1] : rg_q.lo_s[1]) begin
                rg_d.hold = 1'b0;
            end
        end else if (!rg_q.lo_s[1]) begin
            rg_d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.lo_s <= '0;
            rg_q.hi_s <= '0;
            rg_q.hold <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign mrst_n = ~rg_q.hold;

    assert_hold_while_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_on |=> !mrst_n);

    assert_chg_needs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mrst_n) && $past(chg_on)) |-> $past(rg_q.hi_s[1]));

    assert_low_only_reasserts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mrst_n && supply_on && rg_q.lo_s[1]) |=> mrst_n);

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
    parameter int DEB_CYCLES     = 20000,
    parameter int KA_TIMEOUT     = 1500000,
    parameter int LOCKOUT_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n,
    input  logic chg_det,
    input  logic keepalive,
    input  logic bat_above_reset,
    input  logic bat_above_release,
    output logic supply_en,
    output logic mrst_n
);
    import pwr_sup_pkg::*;

    localparam int          LW       = cnt_width(LOCKOUT_CYCLES);
    localparam int          N_WAKE   = 2;
    localparam logic [1:0]  IDLE_VEC = 2'b01;

    logic [N_WAKE-1:0] raw_vec, lvl_vec;
    logic key_pressed, chg_on, wake, ka_expire;

    assign raw_vec = {chg_det, key_n};

    for (genvar gi = 0; gi < N_WAKE; gi++) begin : g_deb
        pwr_deb #(
            .HOLD (DEB_CYCLES),
            .IDLE (IDLE_VEC[gi])
        ) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_vec[gi]),
            .level (lvl_vec[gi])
        );
    end

    assign key_pressed = ~lvl_vec[0];
    assign chg_on      = lvl_vec[1];
    assign wake        = key_pressed | chg_on;

    typedef struct packed {
        pwr_state_e    state;
        logic [LW-1:0] lock_cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            PS_ATTACH: begin
                fsm_d.state = PS_ON;
            end
            PS_ON: begin
                if (ka_expire) begin
                    fsm_d.state    = PS_LOCK;
                    fsm_d.lock_cnt = '0;
                end
            end
            PS_LOCK: begin
                if (fsm_q.lock_cnt == LW'(LOCKOUT_CYCLES - 1)) begin
                    fsm_d.state = PS_OFF;
                end else begin
                    fsm_d.lock_cnt = fsm_q.lock_cnt + 1'b1;
                end
            end
            PS_OFF: begin
                if (wake) begin
                    fsm_d.state = PS_ON;
                end
            end
            default: fsm_d.state = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state    <= PS_ATTACH;
            fsm_q.lock_cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign supply_en = (fsm_q.state == PS_ON);

    pwr_ka #(
        .TIMEOUT (KA_TIMEOUT)
    ) u_ka (
        .clk    (clk),
        .rst_n  (rst_n),
        .ka_raw (keepalive),
        .run    (supply_en),
        .expire (ka_expire)
    );

    pwr_rgate u_rgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_on (supply_en),
        .chg_on    (chg_on),
        .lo_raw    (bat_above_reset),
        .hi_raw    (bat_above_release),
        .mrst_n    (mrst_n)
    );

    assert_off_wakes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == PS_OFF && wake) |=> supply_en);

    assert_cut_on_starve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> $past(ka_expire));

    assert_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(supply_en) && $past(fsm_q.state) != PS_ATTACH) |-> $past(wake));

    assert_no_direct_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_en && !ka_expire) |=> supply_en);

endmodule

// File: tb/sim_pwr_supervisor.sv
module sim_pwr_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int WDOG       = 40;
    localparam int LOCK       = 12;
    localparam int LIMIT      = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_n = 1'b1;
    logic chg_det = 1'b0;
    logic keepalive = 1'b0;
    logic bat_lo = 1'b1;
    logic bat_hi = 1'b1;
    logic supply_en, mrst_n;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_supervisor #(
        .DEB_CYCLES     (DEB),
        .KA_TIMEOUT     (WDOG),
        .LOCKOUT_CYCLES (LOCK)
    ) u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .key_n             (key_n),
        .chg_det           (chg_det),
        .keepalive         (keepalive),
        .bat_above_reset   (bat_lo),
        .bat_above_release (bat_hi),
        .supply_en         (supply_en),
        .mrst_n            (mrst_n)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    endtask

    // reset pulse; returns at the negedge right after the first active edge
    task automatic do_attach(input bit check_reset);
        rst_n = 1'b0;
        cyc(2);
        if (check_reset) begin
            chk("R1 supply in reset", supply_en, 1'b0);
            chk("R1 mrst_n in reset", mrst_n, 1'b0);
        end
        rst_n = 1'b1;
        cyc(1);
    endtask

    // wait n cycles feeding a keep-alive pulse every 10 cycles
    task automatic idle_keep(input int n);
        for (int i = 0; i < n; i++) begin
            keepalive = ((i % 10) < 2);
            cyc(1);
        end
        keepalive = 1'b0;
    endtask

    initial begin
        cyc(1);
        // R1: reset state and attach power-up
        do_attach(1'b1);
        chk("R1 attach powers up", supply_en, 1'b1);

        // R5: exact cut with no keep-alive
        cyc(WDOG - 1);
        chk("R5 still on", supply_en, 1'b1);
        cyc(1);
        chk("R5 cut", supply_en, 1'b0);

        // R7 with key held low; R8 key low while on has no effect
        key_n = 1'b0;
        do_attach(1'b0);
        cyc(WDOG - 1);
        chk("R8 key low keeps on", supply_en, 1'b1);
        cyc(1);
        chk("R5 cut with key held", supply_en, 1'b0);
        cyc(LOCK);
        chk("R7 off through lockout", supply_en, 1'b0);
        cyc(1);
        chk("R7 back on after lockout", supply_en, 1'b1);
        key_n = 1'b1;

        // R7 with no wake source: stays off
        cyc(WDOG + LOCK + 6);
        chk("R7 stays off without source", supply_en, 1'b0);

        // R6: keep-alive held high counts once
        do_attach(1'b0);
        keepalive = 1'b1;
        cyc(WDOG + 2);
        chk("R6 on before single-edge timeout", supply_en, 1'b1);
        cyc(1);
        chk("R6 cut despite held line", supply_en, 1'b0);
        keepalive = 1'b0;
        cyc(LOCK + 4);

        // R4: sweep of keep-alive spacing
        for (int g = 3; g <= WDOG + 3; g++) begin
            do_attach(1'b0);
            for (int k = 0; k < 4; k++) begin
                keepalive = 1'b1;
                cyc(2);
                keepalive = 1'b0;
                cyc(g - 2);
            end
            chk($sformatf("R4 spacing %0d", g), supply_en, (g < WDOG) ? 1'b1 : 1'b0);
        end

        // R2: key glitch width sweep from off
        for (int w = 1; w <= DEB + 1; w++) begin
            do_attach(1'b0);
            cyc(WDOG + LOCK + 4);
            chk("R2 off before press", supply_en, 1'b0);
            key_n = 1'b0;
            cyc(w);
            key_n = 1'b1;
            cyc(DEB + 6);
            chk($sformatf("R2 glitch width %0d", w), supply_en, (w >= DEB) ? 1'b1 : 1'b0);
        end

        // R2: exact latency of a held press
        do_attach(1'b0);
        cyc(WDOG + LOCK + 4);
        key_n = 1'b0;
        cyc(DEB + 2);
        chk("R2 not yet on", supply_en, 1'b0);
        cyc(1);
        chk("R2 on after debounce", supply_en, 1'b1);
        key_n = 1'b1;

        // R3: exact latency of charger detection
        cyc(WDOG + LOCK + 10);
        chk("R3 off before charger", supply_en, 1'b0);
        chg_det = 1'b1;
        cyc(DEB + 2);
        chk("R3 not yet on", supply_en, 1'b0);
        cyc(1);
        chk("R3 on after debounce", supply_en, 1'b1);
        chg_det = 1'b0;
        cyc(WDOG + LOCK + 10);

        // R9/R10 without charger
        bat_lo = 1'b0;
        bat_hi = 1'b0;
        do_attach(1'b0);
        idle_keep(6);
        chk("R9 held with low battery", mrst_n, 1'b0);
        bat_lo = 1'b1;
        idle_keep(6);
        chk("R9 released at reset level", mrst_n, 1'b1);
        bat_lo = 1'b0;
        idle_keep(6);
        chk("R10 reasserted below reset level", mrst_n, 1'b0);

        // R9/R10 with charger
        chg_det = 1'b1;
        do_attach(1'b0);
        idle_keep(DEB + 8);
        chk("R9 held with charger, low battery", mrst_n, 1'b0);
        bat_lo = 1'b1;
        idle_keep(6);
        chk("R9 charger needs release level", mrst_n, 1'b0);
        bat_hi = 1'b1;
        idle_keep(6);
        chk("R9 released at release level", mrst_n, 1'b1);
        bat_hi = 1'b0;
        idle_keep(6);
        chk("R10 hysteresis keeps release", mrst_n, 1'b1);
        bat_lo = 1'b0;
        idle_keep(6);
        chk("R10 reasserted with charger", mrst_n, 1'b0);
        chk("R4 fed supply still on", supply_en, 1'b1);
        chg_det = 1'b0;
        bat_lo = 1'b1;
        bat_hi = 1'b1;

        summary();
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

endmodule